// File: doc/BRIEF.md
# Stereo PCM-to-PWM Output Stage

This block turns a stereo stream of 16-bit signed PCM samples into two single-bit pulse-width-modulated outputs, one per channel. Each accepted sample pair opens an interpolation period of N PWM frames, with N set to 2, 4, 8 or 16. Frame k of that period carries a value that lies on the straight line from the previous sample to the new one. This raises the effective sample rate by N before the pulse-width stage.

The pulse-width stage runs a shared frame counter of 2^W clocks, with W set to 8, 9, 10 or 11 bits. A channel output stays high for as many clocks of the frame as its quantized value. Either channel can be muted to a fixed half-duty tone, which is the analog mid-scale. If the source has nothing to offer when a period ends, the last sample is repeated, so the outputs never stall.

Top module: `pcm_pwm_out`

## Requirements
- R1: `in_ready` is high only in the last clock of the last frame of a period. A sample pair is taken on the clock edge where `in_valid` and `in_ready` are both high, and the next clock starts frame 0 of a new period.
- R2: A sample is converted to offset binary by inverting bit 15. It is then truncated to its upper W bits, so -32768 gives duty 0 and 32767 gives duty 2^W-1.
- R3: A frame lasts 2^W clocks. The output of an unmuted channel is high for exactly `duty` clocks of each frame, and the pulse starts at the beginning of the frame.
- R4: In frame k (0..N-1) of a period from sample a to sample b, both in offset binary, the value is a + floor((b-a)*k / 2^L), with L = os_sel+1. So os_sel 0, 1, 2, 3 select 2x, 4x, 8x, 16x, and frame 0 carries the previous sample.
- R5: If `in_valid` is low when `in_ready` is high, the last sample is held, and every frame of the next period carries that sample.
- R6: A muted channel (`mute_left` or `mute_right` high) outputs 2^(W-1) high clocks per frame. The other channel is unaffected, and a muted channel still takes in and tracks its samples.
- R7: `os_sel` is sampled only at the start of a period. Changing it during a period leaves the remaining frames of that period unchanged.
- R8: `res_sel` is sampled at each frame boundary and sets W = 8 + res_sel, so codes 0, 1, 2, 3 select 8, 9, 10, 11 bits.
- R9: While `rst` is high, both outputs and `in_ready` are low. After reset both channels sit at mid-scale (duty 2^(W-1)) with 2x oversampling and 8-bit frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Sample pair accepted this cycle if valid |
| in_left | input | 16 | Left PCM sample, two's complement |
| in_right | input | 16 | Right PCM sample, two's complement |
| os_sel | input | 2 | Oversampling code, N = 2 << os_sel |
| res_sel | input | 2 | Resolution code, W = 8 + res_sel |
| mute_left | input | 1 | Force left output to half duty |
| mute_right | input | 1 | Force right output to half duty |
| pwm_left | output | 1 | Left pulse-width output |
| pwm_right | output | 1 | Right pulse-width output |

## Verification
The assertions watch the invariants that must hold on every cycle. The frame counter never passes the frame end, and a stored duty never exceeds the frame length. An accepted sample always starts frame 0 of a new period, and a period without a sample keeps the stored sample. The oversampling code stays frozen within a period, the interpolated value stays inside the sample range, and a muted output drops low after the half-frame point. Only the bench scenarios show the actual high-time per frame for each interpolation step and resolution, the exact rounding of falling ramps, the end-scale codes, and the hold behaviour as seen at the outputs.

// File: rtl/pcmpwm_pkg.sv
package pcmpwm_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 2;

  // log2 of the oversampling factor for a select code
  function automatic logic [2:0] step_log2(input logic [SEL_W-1:0] sel);
    return 3'(sel) + 3'd1;
  endfunction
endpackage

// File: rtl/pcm_interp.sv
module pcm_interp #(
  parameter int SMP_W  = 16,
  parameter int STEP_W = 4,
  localparam int PROD_W = SMP_W + STEP_W + 2
) (
  input  logic [SMP_W-1:0]  from_i,
  input  logic [SMP_W-1:0]  to_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [2:0]        shift_i,
  output logic [PROD_W-1:0] value_o
);
  logic signed [SMP_W:0]    diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] part;

  always_comb begin
    diff    = $signed({1'b0, to_i}) - $signed({1'b0, from_i});
    prod    = PROD_W'(diff) * $signed(PROD_W'({1'b0, step_i}));
    part    = prod >>> shift_i;
    value_o = PROD_W'($signed({1'b0, from_i}) + part);
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int CNT_W     = 11,
  parameter int MIN_PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic             mute_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] half;
  logic             pwm_q;

  assign half  = (last_i >> 1) + CNT_W'(1);
  assign pwm_o = pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= CNT_W'(1) << (MIN_PWM_W - 1);
      pwm_q  <= 1'b0;
    end else begin
      if (load_i) duty_q <= duty_i;
      pwm_q <= mute_i ? (cnt_i < half) : (cnt_i < duty_q);
    end
  end

  // R3
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    duty_q <= last_i);

  // R6
  mute_half_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_i && cnt_i >= half) |=> !pwm_o);
endmodule

// File: rtl/pcm_pwm_out.sv
module pcm_pwm_out
  import pcmpwm_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter int MIN_PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_left,
  input  logic [SMP_W-1:0] in_right,
  input  logic [1:0]       os_sel,
  input  logic [1:0]       res_sel,
  input  logic             mute_left,
  input  logic             mute_right,
  output logic             pwm_left,
  output logic             pwm_right
);
  localparam int STEP_W = 1 << SEL_W;
  localparam int CNT_W  = MIN_PWM_W + STEP_W - 1;
  localparam int PROD_W = SMP_W + STEP_W + 2;
  localparam logic [SMP_W-1:0] MID = {1'b1, {(SMP_W-1){1'b0}}};

  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] k_q, k_n;
  logic [SEL_W-1:0]  os_q, os_n, res_q, res_n;
  logic [SMP_W-1:0]  a_q [NUM_CH];
  logic [SMP_W-1:0]  b_q [NUM_CH];
  logic [SMP_W-1:0]  a_n [NUM_CH];
  logic [SMP_W-1:0]  b_n [NUM_CH];
  logic [SMP_W-1:0]  smp_in [NUM_CH];
  logic              mute_v [NUM_CH];
  logic              pwm_v  [NUM_CH];
  logic [PROD_W-1:0] ival   [NUM_CH];
  logic [CNT_W-1:0]  duty_n [NUM_CH];
  logic [CNT_W-1:0]  frame_last;
  logic [STEP_W-1:0] step_last;
  logic              frame_end, period_end, take;

  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;
  assign mute_v[0] = mute_left;
  assign mute_v[1] = mute_right;
  assign pwm_left  = pwm_v[0];
  assign pwm_right = pwm_v[1];

  assign frame_last = CNT_W'((1 << (MIN_PWM_W + int'(res_q))) - 1);
  assign step_last  = STEP_W'((1 << step_log2(os_q)) - 1);
  assign frame_end  = (cnt_q == frame_last);
  assign period_end = frame_end && (k_q == step_last);
  assign in_ready   = period_end;
  assign take       = in_valid && period_end;

  always_comb begin
    k_n   = k_q;
    os_n  = os_q;
    res_n = res_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      a_n[ch] = a_q[ch];
      b_n[ch] = b_q[ch];
    end
    if (frame_end) begin
      res_n = res_sel;
      k_n   = k_q + STEP_W'(1);
    end
    if (period_end) begin
      k_n  = '0;
      os_n = os_sel;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        a_n[ch] = b_q[ch];
        if (take) b_n[ch] = smp_in[ch] ^ MID;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      k_q   <= '0;
      os_q  <= '0;
      res_q <= '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        a_q[ch] <= MID;
        b_q[ch] <= MID;
      end
    end else begin
      cnt_q <= frame_end ? '0 : cnt_q + CNT_W'(1);
      k_q   <= k_n;
      os_q  <= os_n;
      res_q <= res_n;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        a_q[ch] <= a_n[ch];
        b_q[ch] <= b_n[ch];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pcm_interp #(.SMP_W(SMP_W), .STEP_W(STEP_W)) i_interp (
      .from_i (a_n[ch]),
      .to_i   (b_n[ch]),
      .step_i (k_n),
      .shift_i(step_log2(os_n)),
      .value_o(ival[ch])
    );

    assign duty_n[ch] =
      CNT_W'(ival[ch][SMP_W-1:0] >> (SMP_W - MIN_PWM_W - int'(res_n)));

    pwm_slice #(.CNT_W(CNT_W), .MIN_PWM_W(MIN_PWM_W)) i_slice (
      .clk   (clk),
      .rst   (rst),
      .load_i(frame_end),
      .duty_i(duty_n[ch]),
      .cnt_i (cnt_q),
      .last_i(frame_last),
      .mute_i(mute_v[ch]),
      .pwm_o (pwm_v[ch])
    );

    // R5
    hold_sample_chk: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid) |=> (b_q[ch] == $past(b_q[ch])));

    // R4
    interp_range_chk: assert property (@(posedge clk) disable iff (rst)
      ival[ch][PROD_W-1:SMP_W] == '0);
  end

  // R1
  accept_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (cnt_q == '0 && k_q == '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= frame_last);

  // R7
  os_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(os_q));
endmodule

// File: tb/test_pcm_pwm_out.sv
module test_pcm_pwm_out;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {os[37:36], res[35:34], mute_l[33], mute_r[32], left[31:16], right[15:0]}
  localparam logic [37:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 16'h4000, 16'hC000},
    {2'd1, 2'd0, 1'b0, 1'b0, 16'h7FFF, 16'h8000},
    {2'd3, 2'd0, 1'b0, 1'b0, 16'h8000, 16'h7FFF},
    {2'd2, 2'd1, 1'b0, 1'b0, 16'h1234, 16'hF00D},
    {2'd0, 2'd3, 1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {2'd1, 2'd2, 1'b1, 1'b0, 16'h7000, 16'h9000},
    {2'd1, 2'd0, 1'b0, 1'b1, 16'hA5A5, 16'h5A5A},
    {2'd2, 2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0001}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic [1:0] os_sel = '0, res_sel = '0;
  logic mute_left = 1'b0, mute_right = 1'b0, pwm_left, pwm_right;
  int n_chk = 0, n_bad = 0;
  int prev_l = 32768, prev_r = 32768;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_pwm_out i_pcm_pwm_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .os_sel(os_sel),
    .res_sel(res_sel), .mute_left(mute_left), .mute_right(mute_right),
    .pwm_left(pwm_left), .pwm_right(pwm_right)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int to_off(input logic [15:0] s);
    return int'({~s[15], s[14:0]});
  endfunction

  function automatic int exp_duty(input int a, input int b, input int k,
                                  input int lg, input int res);
    int v;
    v = a + (((b - a) * k) >>> lg);
    return v >> (8 - res);
  endfunction

  // counts high cycles over len cycles, starting at the current negedge
  task automatic measure(input int len, output int hl, output int hr,
                         output int rdy);
    hl = 0; hr = 0; rdy = 0;
    for (int i = 0; i < len; i++) begin
      hl += int'(pwm_left);
      hr += int'(pwm_right);
      rdy += int'(in_ready);
      @(negedge clk);
    end
  endtask

  // offers a pair, returns at the negedge two cycles after acceptance
  task automatic offer(input logic [15:0] l, input logic [15:0] r);
    in_left = l; in_right = r; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hl, hr, rdy;
    repeat (4) @(negedge clk);
    check("R9 pwm_left in reset", int'(pwm_left), 0);
    check("R9 pwm_right in reset", int'(pwm_right), 0);
    check("R9 in_ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int f = 0; f < 2; f++) begin
      measure(256, hl, hr, rdy);
      check("R9 left mid-scale after reset", hl, 128);
      check("R9 right mid-scale after reset", hr, 128);
    end

    for (int v = 0; v < NVEC; v++) begin
      int os, res, n, w, ml, mr, nl, nr;
      os = int'(VEC[v][37:36]); res = int'(VEC[v][35:34]);
      ml = int'(VEC[v][33]); mr = int'(VEC[v][32]);
      n = 2 << os; w = 8 + res;
      nl = to_off(VEC[v][31:16]); nr = to_off(VEC[v][15:0]);
      os_sel = VEC[v][37:36]; res_sel = VEC[v][35:34];
      mute_left = VEC[v][33]; mute_right = VEC[v][32];
      offer(VEC[v][31:16], VEC[v][15:0]);
      os_sel = ~VEC[v][37:36];  // R7: must not alter this period
      for (int k = 0; k < n; k++) begin
        measure(1 << w, hl, hr, rdy);
        check("R2 R3 R4 R6 R7 R8 left frame", hl,
              ml != 0 ? (1 << (w - 1)) : exp_duty(prev_l, nl, k, os + 1, res));
        check("R2 R3 R4 R6 R7 R8 right frame", hr,
              mr != 0 ? (1 << (w - 1)) : exp_duty(prev_r, nr, k, os + 1, res));
        check("R1 ready only at period end", rdy, (k == n - 1) ? 1 : 0);
      end
      measure(1 << w, hl, hr, rdy);
      check("R5 left held", hl, ml != 0 ? (1 << (w - 1)) : (nl >> (8 - res)));
      check("R5 right held", hr, mr != 0 ? (1 << (w - 1)) : (nr >> (8 - res)));
      prev_l = nl; prev_r = nr;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule